// File: doc/BRIEF.md
# Lockable Cache Way Replacement Selector

This block chooses which way of a 4-way set-associative cache receives a new line when an access misses. It also keeps a 3-bit tree pseudo-LRU record for every set, and updates that record on every hit and every fill. A single 32-bit control word sets the lock behaviour. Software can mark way 2 and way 3 as locked. It can also steer prefetch fills into one of those ways. Lock mode can follow an external processor DSP-mode status bit, or it can be forced on.

Each access comes in on a valid/ready channel. An access carries a set index, a hit flag, the way that hit, and a prefetch flag. Tag comparison, the data arrays, refill and the bus interface sit outside this block. When a miss is accepted, the chosen way appears one cycle later on a valid/ready result channel.

Back-pressure rules:
- A result that is not taken holds its value.
- While a result waits and `vic_ready` is low, `acc_ready` is low, so no further access is accepted.
- A hit is accepted under the same condition as a miss, but it produces no result.

Top module: `lockway_victim_sel`

## Requirements
- R1: After reset, the control word reads 0 and `vic_valid` is 0. Every set starts with pseudo-LRU state 000, so the first miss on any set selects way 0.
- R2: The writable control fields sit at these bit positions:
  - bit 16: force lock mode on
  - bit 9: way-3 load
  - bit 8: way-3 lock
  - bit 1: way-2 load
  - bit 0: way-2 lock

  All other bits read as 0, whatever value was written to them.
- R3: Lock mode is active when bit 16 is 1, or when `dsp_mode` is 1. With bit 16 clear and `dsp_mode` low, the lock and load bits have no effect on the chosen way.
- R4: A prefetch miss in lock mode, with bits 9 and 8 both set, selects way 3.
- R5: A prefetch miss in lock mode, with bits 1 and 0 both set and the way-3 pair not both set, selects way 2.
- R6: If both load bits and both lock bits are set, a prefetch miss in lock mode selects way 3.
- R7: In every other case a miss selects the pseudo-LRU victim. This includes a prefetch miss with a load bit set but its lock bit clear, and a prefetch miss outside lock mode.
- R8: A non-prefetch miss in lock mode never selects a way whose lock bit is set. Within the tree, a locked preferred way yields to its pair partner. If both way 2 and way 3 are locked, the left pair (ways 0 and 1) is used.
- R9: The pseudo-LRU tree uses 3 bits per set:
  - bit 0 picks the pair: 0 means ways 0/1, 1 means ways 2/3.
  - bit 1 picks within ways 0/1: 0 means way 0.
  - bit 2 picks within ways 2/3: 0 means way 2.

  Each hit or fill sets the bits to point away from the touched way. Sets are independent. From reset, five misses on one set select ways 0, 2, 1, 3, 0.
- R10: `vic_valid` rises one cycle after an accepted miss, and carries the chosen way. An accepted hit produces no result.
- R11: While `vic_valid` is 1 and `vic_ready` is 0, `vic_way` holds its value and `acc_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| dsp_mode | input | 1 | Processor DSP-mode status bit |
| acc_valid | input | 1 | Access presented |
| acc_ready | output | 1 | Access accepted this cycle when high with acc_valid |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_hit_way | input | 2 | Way that hit |
| acc_prefetch | input | 1 | Access is a prefetch |
| vic_valid | output | 1 | Chosen way available |
| vic_ready | input | 1 | Consumer takes the chosen way |
| vic_way | output | 2 | Chosen way for the fill |

## Verification
The assertions assume two things about the inputs. First, `reg_rdata` and `dsp_mode` describe the configuration used in the same cycle an access is accepted. Second, `acc_hit_way` is meaningful only when `acc_hit` is high.

The stimulus keeps to these assumptions:
- It changes the control word only while no access is presented.
- It changes `dsp_mode` only between accesses.
- It drives `acc_hit_way` only on hits.
- It keeps `vic_ready` high, except in the scenario that tests stalls. There, a second access is held on the input until the result drains.

// File: rtl/lockway_pkg.sv
package lockway_pkg;
  localparam int WAYS    = 4;
  localparam int WAY_W   = 2;
  localparam int TREE_W  = WAYS - 1;

  localparam int BIT_FORCE = 16;
  localparam int BIT_W3LD  = 9;
  localparam int BIT_W3LK  = 8;
  localparam int BIT_W2LD  = 1;
  localparam int BIT_W2LK  = 0;

  localparam logic [31:0] CFG_MASK = (32'd1 << BIT_FORCE) | (32'd1 << BIT_W3LD) |
                                     (32'd1 << BIT_W3LK)  | (32'd1 << BIT_W2LD) |
                                     (32'd1 << BIT_W2LK);

  typedef struct packed {
    logic force_on;
    logic w3_load;
    logic w3_lock;
    logic w2_load;
    logic w2_lock;
  } lock_cfg_t;
endpackage

// File: rtl/lw_cfg_reg.sv
module lw_cfg_reg
  import lockway_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output lock_cfg_t   cfg
);
  lock_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.force_on <= wdata[BIT_FORCE];
      cfg_q.w3_load  <= wdata[BIT_W3LD];
      cfg_q.w3_lock  <= wdata[BIT_W3LK];
      cfg_q.w2_load  <= wdata[BIT_W2LD];
      cfg_q.w2_lock  <= wdata[BIT_W2LK];
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[BIT_FORCE] = cfg_q.force_on;
    rdata[BIT_W3LD]  = cfg_q.w3_load;
    rdata[BIT_W3LK]  = cfg_q.w3_lock;
    rdata[BIT_W2LD]  = cfg_q.w2_load;
    rdata[BIT_W2LK]  = cfg_q.w2_lock;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lw_plru_store.sv
module lw_plru_store
  import lockway_pkg::*;
#(
  parameter int SETS  = 64,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [TREE_W-1:0] rd_state,
  input  logic              upd_en,
  input  logic [SET_W-1:0]  upd_set,
  input  logic [WAY_W-1:0]  upd_way
);
  logic [TREE_W-1:0] tree_q [SETS];
  logic [TREE_W-1:0] touched;

  // Point every tree bit on the path away from the touched way.
  always_comb begin
    touched = tree_q[upd_set];
    touched[0] = ~upd_way[1];
    if (upd_way[1]) touched[2] = ~upd_way[0];
    else            touched[1] = ~upd_way[0];
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk) begin
      if (!rst_n)                                     tree_q[s] <= '0;
      else if (upd_en && upd_set == SET_W'(s))        tree_q[s] <= touched;
    end
  end

  assign rd_state = tree_q[rd_set];
endmodule

// File: rtl/lw_victim_pick.sv
module lw_victim_pick
  import lockway_pkg::*;
(
  input  logic [TREE_W-1:0] tree,
  input  lock_cfg_t         cfg,
  input  logic              dsp_mode,
  input  logic              prefetch,
  output logic [WAY_W-1:0]  way
);
  logic lock_mode, pin3, pin2, avoid, lk2, lk3;
  logic pref_lk, right_ok;
  logic [WAY_W-1:0] left_way, pref_way, alt_way, right_way, lru_way;

  always_comb begin
    lock_mode = cfg.force_on | dsp_mode;
    pin3      = prefetch & lock_mode & cfg.w3_load & cfg.w3_lock;
    pin2      = prefetch & lock_mode & cfg.w2_load & cfg.w2_lock;
    avoid     = lock_mode & ~prefetch;
    lk2       = avoid & cfg.w2_lock;
    lk3       = avoid & cfg.w3_lock;

    left_way  = tree[1] ? 2'd1 : 2'd0;
    pref_way  = tree[2] ? 2'd3 : 2'd2;
    alt_way   = tree[2] ? 2'd2 : 2'd3;
    pref_lk   = tree[2] ? lk3 : lk2;
    right_way = pref_lk ? alt_way : pref_way;
    right_ok  = ~(lk2 & lk3);
    lru_way   = (tree[0] && right_ok) ? right_way : left_way;

    if (pin3)      way = 2'd3;
    else if (pin2) way = 2'd2;
    else           way = lru_way;
  end
endmodule

// File: rtl/lockway_victim_sel.sv
module lockway_victim_sel
  import lockway_pkg::*;
#(
  parameter int SETS  = 64,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             dsp_mode,
  input  logic             acc_valid,
  output logic             acc_ready,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_hit,
  input  logic [1:0]       acc_hit_way,
  input  logic             acc_prefetch,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [1:0]       vic_way
);
  lock_cfg_t         cfg;
  logic [TREE_W-1:0] tree;
  logic [WAY_W-1:0]  pick, upd_way;
  logic              fire, miss_fire;
  logic              vld_q;
  logic [WAY_W-1:0]  way_q;

  lw_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg)
  );

  lw_plru_store #(.SETS(SETS)) u_lru (
    .clk(clk), .rst_n(rst_n), .rd_set(acc_set), .rd_state(tree),
    .upd_en(fire), .upd_set(acc_set), .upd_way(upd_way)
  );

  lw_victim_pick u_pick (
    .tree(tree), .cfg(cfg), .dsp_mode(dsp_mode),
    .prefetch(acc_prefetch), .way(pick)
  );

  assign acc_ready = ~vld_q | vic_ready;
  assign fire      = acc_valid & acc_ready;
  assign miss_fire = fire & ~acc_hit;
  assign upd_way   = acc_hit ? acc_hit_way : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      way_q <= '0;
    end else if (miss_fire) begin
      vld_q <= 1'b1;
      way_q <= pick;
    end else if (vic_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign vic_valid = vld_q;
  assign vic_way   = way_q;
endmodule

// File: rtl/lockway_victim_sel_chk.sv
module lockway_victim_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        dsp_mode,
  input logic        acc_valid,
  input logic        acc_ready,
  input logic        acc_hit,
  input logic        acc_prefetch,
  input logic        vic_valid,
  input logic        vic_ready,
  input logic [1:0]  vic_way
);
  logic lock_on, take_miss;
  assign lock_on   = reg_rdata[16] | dsp_mode;
  assign take_miss = acc_valid & acc_ready & ~acc_hit;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~32'h0001_0303) == 32'd0);

  assert_pin_way3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_miss && acc_prefetch && lock_on && reg_rdata[9] && reg_rdata[8])
    |=> (vic_valid && vic_way == 2'd3));

  assert_pin_way2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_miss && acc_prefetch && lock_on && reg_rdata[1] && reg_rdata[0] &&
     !(reg_rdata[9] && reg_rdata[8]))
    |=> (vic_valid && vic_way == 2'd2));

  assert_skip_lock3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_miss && !acc_prefetch && lock_on && reg_rdata[8]) |=> (vic_way != 2'd3));

  assert_skip_lock2_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_miss && !acc_prefetch && lock_on && reg_rdata[0]) |=> (vic_way != 2'd2));

  assert_miss_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_miss |=> vic_valid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_miss && !(vic_valid && !vic_ready)) |=> !vic_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_way)));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |-> !acc_ready);
endmodule

bind lockway_victim_sel lockway_victim_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .dsp_mode(dsp_mode),
  .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_hit(acc_hit),
  .acc_prefetch(acc_prefetch), .vic_valid(vic_valid), .vic_ready(vic_ready),
  .vic_way(vic_way)
);

// File: tb/sim_lockway_victim_sel.sv
`timescale 1ns/1ps
module sim_lockway_victim_sel;
  localparam int SETS = 64;
  localparam int SW   = $clog2(SETS);

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic dsp_mode, acc_valid, acc_ready, acc_hit, acc_prefetch;
  logic [SW-1:0] acc_set;
  logic [1:0] acc_hit_way, vic_way;
  logic vic_valid, vic_ready;

  int checks = 0;
  int errors = 0;
  logic [31:0] cfg_m;
  logic [2:0]  tree_m [SETS];

  always #4 clk = ~clk;

  lockway_victim_sel #(.SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dsp_mode(dsp_mode), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_set(acc_set), .acc_hit(acc_hit),
    .acc_hit_way(acc_hit_way), .acc_prefetch(acc_prefetch),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_way(vic_way)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected way, from the rules stated in R3..R9.
  function automatic logic [1:0] expect_way(input int s, input bit pf);
    logic [2:0] t;
    bit lm, l2, l3;
    logic [1:0] r;
    t  = tree_m[s];
    lm = cfg_m[16] | dsp_mode;
    if (pf && lm && cfg_m[9] && cfg_m[8]) return 2'd3;
    if (pf && lm && cfg_m[1] && cfg_m[0]) return 2'd2;
    l2 = lm && !pf && cfg_m[0];
    l3 = lm && !pf && cfg_m[8];
    r  = t[2] ? 2'd3 : 2'd2;
    if ((r == 2'd3 && l3) || (r == 2'd2 && l2)) r = (r == 2'd3) ? 2'd2 : 2'd3;
    if (t[0] && !(l2 && l3)) return r;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic void touch(input int s, input logic [1:0] w);
    tree_m[s][0] = ~w[1];
    if (w[1]) tree_m[s][2] = ~w[0];
    else      tree_m[s][1] = ~w[0];
  endfunction

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    cfg_m = v & 32'h0001_0303;
  endtask

  task automatic do_miss(input int s, input bit pf, input string req);
    logic [1:0] e;
    e = expect_way(s, pf);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(s); acc_hit = 1'b0; acc_prefetch = pf;
    @(negedge clk);
    acc_valid = 1'b0;
    chk(vic_valid === 1'b1, {req, " valid"}, 32'(vic_valid), 1);
    chk(vic_way === e, {req, " way"}, 32'(vic_way), 32'(e));
    touch(s, e);
  endtask

  task automatic do_hit(input int s, input logic [1:0] w);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(s); acc_hit = 1'b1; acc_hit_way = w;
    acc_prefetch = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0; acc_hit = 1'b0;
    chk(vic_valid === 1'b0, "R10 hit gives no result", 32'(vic_valid), 0);
    touch(s, w);
  endtask

  task automatic t_reset;
    chk(reg_rdata === 32'd0, "R1 reg after reset", reg_rdata, 0);
    chk(vic_valid === 1'b0, "R1 no result after reset", 32'(vic_valid), 0);
    do_miss(0, 1'b0, "R1 first miss");
    chk(vic_way === 2'd0, "R1 first miss way0", 32'(vic_way), 0);
  endtask

  task automatic t_register;
    write_cfg(32'hFFFF_FFFF);
    chk(reg_rdata === 32'h0001_0303, "R2 reserved read zero", reg_rdata, 32'h0001_0303);
    write_cfg(32'h0001_0000);
    chk(reg_rdata === 32'h0001_0000, "R2 force bit 16", reg_rdata, 32'h0001_0000);
    write_cfg(32'h0);
    chk(reg_rdata === 32'h0, "R2 clear", reg_rdata, 0);
  endtask

  task automatic t_plru;
    logic [1:0] seq [5] = '{2'd0, 2'd2, 2'd1, 2'd3, 2'd0};
    for (int i = 0; i < 5; i++) begin
      do_miss(5, 1'b0, "R9 tree order");
      chk(vic_way === seq[i], "R9 fixed sequence", 32'(vic_way), 32'(seq[i]));
    end
    do_hit(5, 2'd2);
    do_miss(5, 1'b0, "R9 after hit");
    do_miss(6, 1'b0, "R9 independent set");
  endtask

  task automatic t_gate;
    write_cfg(32'h0000_0300);
    dsp_mode = 1'b0;
    do_miss(10, 1'b1, "R3 gated off");
    dsp_mode = 1'b1;
    do_miss(10, 1'b1, "R3 dsp on");
    chk(vic_way === 2'd3, "R4 pinned by dsp", 32'(vic_way), 3);
    dsp_mode = 1'b0;
    write_cfg(32'h0001_0300);
    do_miss(11, 1'b1, "R4 forced mode");
    chk(vic_way === 2'd3, "R4 pinned by force", 32'(vic_way), 3);
  endtask

  task automatic t_way2;
    write_cfg(32'h0001_0003);
    do_miss(12, 1'b1, "R5 pin way2");
    chk(vic_way === 2'd2, "R5 way2", 32'(vic_way), 2);
    write_cfg(32'h0001_0303);
    do_miss(12, 1'b1, "R6 both set");
    chk(vic_way === 2'd3, "R6 way3 wins", 32'(vic_way), 3);
  endtask

  task automatic t_lru_fallback;
    write_cfg(32'h0001_0200);
    do_miss(13, 1'b1, "R7 load without lock");
    chk(vic_way === 2'd0, "R7 lru way0", 32'(vic_way), 0);
    write_cfg(32'h0000_0303);
    dsp_mode = 1'b0;
    do_miss(13, 1'b1, "R7 outside lock mode");
    chk(vic_way === 2'd2, "R7 lru way2", 32'(vic_way), 2);
  endtask

  task automatic t_avoid;
    write_cfg(32'h0001_0100);
    for (int i = 0; i < 6; i++) begin
      do_miss(20, 1'b0, "R8 way3 locked");
      chk(vic_way !== 2'd3, "R8 not way3", 32'(vic_way), 0);
    end
    write_cfg(32'h0001_0101);
    for (int i = 0; i < 4; i++) begin
      do_miss(21, 1'b0, "R8 both locked");
      chk(vic_way[1] === 1'b0, "R8 left pair only", 32'(vic_way), 0);
    end
    write_cfg(32'h0);
  endtask

  task automatic t_stall;
    logic [1:0] e1, e2;
    vic_ready = 1'b0;
    e1 = expect_way(30, 1'b0);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = SW'(30); acc_hit = 1'b0; acc_prefetch = 1'b0;
    @(negedge clk);
    touch(30, e1);
    acc_set = SW'(31);
    chk(vic_valid === 1'b1 && vic_way === e1, "R10 first result", 32'(vic_way), 32'(e1));
    chk(acc_ready === 1'b0, "R11 stalled input", 32'(acc_ready), 0);
    @(negedge clk);
    chk(vic_valid === 1'b1 && vic_way === e1, "R11 held result", 32'(vic_way), 32'(e1));
    e2 = expect_way(31, 1'b0);
    vic_ready = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    touch(31, e2);
    chk(vic_valid === 1'b1 && vic_way === e2, "R11 drained then next", 32'(vic_way), 32'(e2));
    @(negedge clk);
    chk(vic_valid === 1'b0, "R10 result cleared", 32'(vic_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; dsp_mode = 1'b0;
    acc_valid = 1'b0; acc_set = '0; acc_hit = 1'b0; acc_hit_way = '0;
    acc_prefetch = 1'b0; vic_ready = 1'b1; cfg_m = '0;
    for (int i = 0; i < SETS; i++) tree_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_register;
    t_plru;
    t_gate;
    t_way2;
    t_lru_fallback;
    t_avoid;
    t_stall;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule